// File: doc/BRIEF.md
# DMA Channel Status Register

This block holds the status word of a four-channel DMA engine. Each channel raises single-cycle event pulses when its transfer count runs out, when an end-of-transfer request arrives, when an error occurs, and when an internal or external request is seen. Each pulse sets a sticky flag. Software reads all flags as one 32-bit word. It clears flags by writing a word with a 1 in each position to clear. A 0 in a position leaves that flag as it was. Two further groups in the word show live channel state: a busy flag and a scatter/gather-active flag for each channel. Writes do not affect these two groups.

The block also gates the channels. A channel gets a run permit only while its terminal-count, end-of-transfer and error flags are all clear. A channel running a scatter/gather chain pauses when one of those conditions fires. The pause latches and holds until software has cleared the blocking flags. This keeps a chain from moving past an event that software has not yet seen.

Top module: `dma_chan_status`

## Requirements
- R1: After a synchronous reset, every sticky flag and every pause latch is 0. With `busy_live` and `sg_live` low, `rd_data` reads 0, `run_ok` is all ones and `sg_paused` is all zeros.
- R2: Bits are numbered from the MSB, so register bit k is `rd_data[31-k]`. Channel n of group g is at register bit 4*g+n. The groups are: g=0 terminal count, g=1 end of transfer, g=2 error, g=3 internal request, g=4 external request, g=5 busy, g=6 scatter/gather active.
- R3: An event pulse sets its flag on the next clock edge. The flag then holds until it is cleared.
- R4: A write with `wr_en` high clears each sticky flag whose register bit in `wr_data` is 1. Flags whose bit is 0 are unchanged.
- R5: If an event pulse and a write-one-to-clear hit the same flag on the same edge, the flag ends up set.
- R6: An end-of-transfer pulse on a channel whose `eot_dis` bit is 1 is ignored. It sets no flag and starts no pause.
- R7: The busy and scatter/gather-active groups always show `busy_live` and `sg_live`. Writes do not affect them.
- R8: Register bits 28 to 31, which are `rd_data[3:0]`, always read 0.
- R9: `run_ok[n]` is 0 while any of channel n's terminal-count, end-of-transfer or error flags is set. Internal and external request flags do not block a channel.
- R10: A blocking event that sets on a channel whose `sg_live` bit is high sets `sg_paused[n]` on the same edge. The pause holds while any blocking flag of that channel is set. It drops one cycle after the last of those flags clears. `run_ok[n]` stays 0 while the channel is paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write-one-to-clear mask |
| rd_data | output | 32 | Status word |
| tc_evt | input | 4 | Transfer count reached zero, one bit per channel |
| eot_evt | input | 4 | End-of-transfer request pulse |
| eot_dis | input | 4 | End-of-transfer disable per channel |
| err_evt | input | 4 | Error pulse |
| ireq_evt | input | 4 | Internal request pulse |
| xreq_evt | input | 4 | External request pulse |
| busy_live | input | 4 | Live channel busy state |
| sg_live | input | 4 | Live scatter/gather-active state |
| run_ok | output | 4 | Per-channel run permit |
| sg_paused | output | 4 | Per-channel scatter/gather pause |

## Verification
The bench drives an event and a clear at the same flag on the same edge. A design that gives priority to the clear would lose that event and read 0. It writes all ones to the register to show that the live groups survive and that the unused bits stay 0. A design that decodes bit positions LSB-first would move every flag to the wrong place. The bench follows a scatter/gather pause through its release, so a latch that drops early or never drops shows up as a wrong `run_ok`. It also confirms that end-of-transfer pulses on a disabled channel change nothing. Random traffic runs against a bench model that checks every output on every cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int unsigned NCH      = 4;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned N_STICKY = 5;
    localparam int unsigned N_GROUPS = 7;

    typedef enum int unsigned {
        G_TC   = 0,
        G_EOT  = 1,
        G_ERR  = 2,
        G_IREQ = 3,
        G_XREQ = 4,
        G_BUSY = 5,
        G_SG   = 6
    } grp_e;

    // Register bits are numbered from the MSB; convert to a vector index.
    function automatic int unsigned reg_pos(int unsigned grp, int unsigned ch);
        return REG_W - 1 - (grp * NCH + ch);
    endfunction
endpackage

// File: rtl/dcs_flag_bank.sv
module dcs_flag_bank #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // set has priority over clear so no event is lost
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end

    assign q_o = q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> q[i]);
        a_r4_clear: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !q[i]);
        a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[i] && !set_i[i]) |=> $stable(q[i]));
    end
endmodule

// File: rtl/dcs_chan_gate.sv
module dcs_chan_gate (
    input  logic clk,
    input  logic rst,
    input  logic blk_set,
    input  logic blk_pend,
    input  logic sg_live,
    output logic run_ok,
    output logic paused
);
    logic paused_q;

    always_ff @(posedge clk) begin
        if (rst) paused_q <= 1'b0;
        else     paused_q <= (sg_live & blk_set) | (paused_q & blk_pend);
    end

    assign paused = paused_q;
    assign run_ok = ~blk_pend & ~paused_q;

    a_r10_needs_sg: assert property (@(posedge clk) disable iff (rst)
        $rose(paused_q) |-> $past(sg_live));
    a_r10_holds: assert property (@(posedge clk) disable iff (rst)
        (paused_q && blk_pend) |=> paused_q);
    a_r10_releases: assert property (@(posedge clk) disable iff (rst)
        (!blk_set && !blk_pend) |=> !paused_q);
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [NCH-1:0]   tc_evt,
    input  logic [NCH-1:0]   eot_evt,
    input  logic [NCH-1:0]   eot_dis,
    input  logic [NCH-1:0]   err_evt,
    input  logic [NCH-1:0]   ireq_evt,
    input  logic [NCH-1:0]   xreq_evt,
    input  logic [NCH-1:0]   busy_live,
    input  logic [NCH-1:0]   sg_live,
    output logic [NCH-1:0]   run_ok,
    output logic [NCH-1:0]   sg_paused
);
    localparam int unsigned USED_BITS = N_GROUPS * NCH;

    logic [NCH-1:0] set_g [N_STICKY];
    logic [NCH-1:0] clr_g [N_STICKY];
    logic [NCH-1:0] q_g   [N_STICKY];
    logic [NCH-1:0] blk_set, blk_pend;

    always_comb begin
        set_g[G_TC]   = tc_evt;
        set_g[G_EOT]  = eot_evt & ~eot_dis;
        set_g[G_ERR]  = err_evt;
        set_g[G_IREQ] = ireq_evt;
        set_g[G_XREQ] = xreq_evt;
    end

    // write-one-to-clear decode, MSB-first bit numbering
    always_comb begin
        for (int g = 0; g < N_STICKY; g++)
            for (int n = 0; n < NCH; n++)
                clr_g[g][n] = wr_en & wr_data[reg_pos(g, n)];
    end

    for (genvar g = 0; g < N_STICKY; g++) begin : g_bank
        dcs_flag_bank #(.W(NCH)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .set_i(set_g[g]),
            .clr_i(clr_g[g]),
            .q_o  (q_g[g])
        );
    end

    assign blk_set  = set_g[G_TC] | set_g[G_EOT] | set_g[G_ERR];
    assign blk_pend = q_g[G_TC] | q_g[G_EOT] | q_g[G_ERR];

    for (genvar n = 0; n < NCH; n++) begin : g_gate
        dcs_chan_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .blk_set (blk_set[n]),
            .blk_pend(blk_pend[n]),
            .sg_live (sg_live[n]),
            .run_ok  (run_ok[n]),
            .paused  (sg_paused[n])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < N_STICKY; g++)
            for (int n = 0; n < NCH; n++)
                rd_data[reg_pos(g, n)] = q_g[g][n];
        for (int n = 0; n < NCH; n++) begin
            rd_data[reg_pos(G_BUSY, n)] = busy_live[n];
            rd_data[reg_pos(G_SG, n)]   = sg_live[n];
        end
    end

    initial begin
        a_r2_fits: assert (USED_BITS <= REG_W);
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        a_r6_eot_masked: assert property (@(posedge clk) disable iff (rst)
            (eot_dis[n] && !q_g[G_EOT][n]) |=> !q_g[G_EOT][n]);
        a_r9_err_blocks: assert property (@(posedge clk) disable iff (rst)
            q_g[G_ERR][n] |-> !run_ok[n]);
        a_r9_tc_blocks: assert property (@(posedge clk) disable iff (rst)
            q_g[G_TC][n] |-> !run_ok[n]);
        a_r10_pause_blocks: assert property (@(posedge clk) disable iff (rst)
            sg_paused[n] |-> !run_ok[n]);
    end
endmodule

// File: tb/dma_chan_status_test.sv
`timescale 1ns/1ps
module dma_chan_status_test;
    localparam int NCH = 4;

    logic        clk = 0, rst = 1, wr_en = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic [3:0]  tc_evt = 0, eot_evt = 0, eot_dis = 0, err_evt = 0;
    logic [3:0]  ireq_evt = 0, xreq_evt = 0, busy_live = 0, sg_live = 0;
    logic [3:0]  run_ok, sg_paused;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state: groups 0..4 sticky
    logic [3:0] m_q [5];
    logic [3:0] m_pause;

    always #4 clk = ~clk;

    dma_chan_status uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tc_evt(tc_evt), .eot_evt(eot_evt), .eot_dis(eot_dis), .err_evt(err_evt),
        .ireq_evt(ireq_evt), .xreq_evt(xreq_evt), .busy_live(busy_live),
        .sg_live(sg_live), .run_ok(run_ok), .sg_paused(sg_paused)
    );

    function automatic int pos(int g, int n);
        return 31 - (g * 4 + n);
    endfunction

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        for (int g = 0; g < 5; g++)
            for (int n = 0; n < NCH; n++) r[pos(g, n)] = m_q[g][n];
        for (int n = 0; n < NCH; n++) begin
            r[pos(5, n)] = busy_live[n];
            r[pos(6, n)] = sg_live[n];
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_run();
        return ~(m_q[0] | m_q[1] | m_q[2]) & ~m_pause;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [3:0] set_v [5];
        logic [3:0] pend, bset;
        set_v[0] = tc_evt; set_v[1] = eot_evt & ~eot_dis; set_v[2] = err_evt;
        set_v[3] = ireq_evt; set_v[4] = xreq_evt;
        pend = m_q[0] | m_q[1] | m_q[2];
        bset = set_v[0] | set_v[1] | set_v[2];
        if (rst) begin
            for (int g = 0; g < 5; g++) m_q[g] = '0;
            m_pause = '0;
        end else begin
            m_pause = (sg_live & bset) | (m_pause & pend);
            for (int g = 0; g < 5; g++)
                for (int n = 0; n < NCH; n++) begin
                    if (wr_en && wr_data[pos(g, n)]) m_q[g][n] = 1'b0;
                    if (set_v[g][n]) m_q[g][n] = 1'b1;
                end
        end
    endtask

    // one clock: inputs held across the edge, then compare everything
    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        check("R3 rd_data", rd_data, exp_rd());
        check("R9 run_ok", {28'd0, run_ok}, {28'd0, exp_run()});
        check("R10 sg_paused", {28'd0, sg_paused}, {28'd0, m_pause});
    endtask

    task automatic quiet();
        wr_en = 0; wr_data = 0; tc_evt = 0; eot_evt = 0; err_evt = 0;
        ireq_evt = 0; xreq_evt = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int g = 0; g < 5; g++) m_q[g] = '0;
        m_pause = '0;
        rst = 1;
        repeat (3) cycle();
        rst = 0;
        cycle();
        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 run_ok", {28'd0, run_ok}, 32'hF);
        check("R1 sg_paused", {28'd0, sg_paused}, 32'h0);

        // R2 position of channel 2 terminal count is rd_data[29]
        tc_evt = 4'b0100; cycle(); quiet();
        check("R2 tc ch2 position", rd_data, 32'h2000_0000);
        // R4 zero write leaves flag
        wr_en = 1; wr_data = 32'h0; cycle(); quiet();
        check("R4 zero write keeps", rd_data, 32'h2000_0000);
        wr_en = 1; wr_data = 32'h2000_0000; cycle(); quiet();
        check("R4 w1c clears", rd_data, 32'h0);

        // R5 set wins against same-cycle clear (ch1 tc = bit 30)
        tc_evt = 4'b0010; wr_en = 1; wr_data = 32'h4000_0000; cycle(); quiet();
        check("R5 set wins", rd_data, 32'h4000_0000);
        wr_en = 1; wr_data = 32'hFFFF_FFFF; cycle(); quiet();

        // R6 eot on disabled ch0 ignored (eot ch0 = bit 27)
        eot_dis = 4'b0001; eot_evt = 4'b0001; sg_live = 4'b0001; cycle(); quiet();
        check("R6 eot masked", rd_data & 32'h0800_0000, 32'h0);
        check("R6 no pause", {28'd0, sg_paused}, 32'h0);
        sg_live = 0; eot_dis = 0; eot_evt = 4'b0001; cycle(); quiet();
        check("R6 eot enabled sets", rd_data, 32'h0800_0000);

        // R7/R8 live mirrors survive all-ones write, unused bits zero
        busy_live = 4'b1010; sg_live = 4'b0110;
        tc_evt = 4'hF; err_evt = 4'hF; ireq_evt = 4'hF; xreq_evt = 4'hF; cycle(); quiet();
        check("R8 unused zero", rd_data & 32'hF, 32'h0);
        wr_en = 1; wr_data = 32'hFFFF_FFFF; cycle(); quiet();
        check("R7 live kept", rd_data, (32'h1 << pos(5,1)) | (32'h1 << pos(5,3))
                                      | (32'h1 << pos(6,1)) | (32'h1 << pos(6,2)));
        cycle(); cycle();
        busy_live = 0; sg_live = 0; cycle();

        // R9 request flags do not block
        ireq_evt = 4'b1000; xreq_evt = 4'b1000; cycle(); quiet();
        check("R9 req not blocking", {28'd0, run_ok}, 32'hF);
        err_evt = 4'b1000; cycle(); quiet();
        check("R9 err blocks", {28'd0, run_ok}, 32'h7);
        wr_en = 1; wr_data = 32'hFFFF_FFFF; cycle(); quiet();

        // R10 scatter/gather pause lifecycle on ch0
        sg_live = 4'b0001; err_evt = 4'b0001; cycle(); quiet();
        check("R10 paused set", {28'd0, sg_paused}, 32'h1);
        cycle();
        check("R10 paused held", {28'd0, sg_paused}, 32'h1);
        wr_en = 1; wr_data = 32'h1 << pos(2, 0); cycle(); quiet();
        check("R10 still paused after clear", {28'd0, sg_paused}, 32'h1);
        check("R10 run_ok low while paused", {28'd0, run_ok[0]}, 32'h0);
        cycle();
        check("R10 released", {28'd0, sg_paused}, 32'h0);
        check("R10 run_ok back", {28'd0, run_ok[0]}, 32'h1);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            tc_evt   = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
            eot_evt  = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
            err_evt  = (($urandom % 12) == 0) ? 4'($urandom) : 4'h0;
            ireq_evt = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            xreq_evt = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
            if (($urandom % 16) == 0) eot_dis = 4'($urandom);
            if (($urandom % 10) == 0) busy_live = 4'($urandom);
            if (($urandom % 20) == 0) sg_live = 4'($urandom);
            wr_en   = (($urandom % 5) == 0);
            wr_data = $urandom;
            if (i % 500 == 250) begin rst = 1; cycle(); rst = 0; end
            cycle();
        end
        quiet();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule